// File: doc/BRIEF.md
# Cascadable Counter with Output Register

This block is a binary counter whose value is never presented directly. An internal count register advances on the count clock. A holding register copies the count on its own register clock, and only that holding register reaches the outputs. The two clocks are independent. Software-free glue can therefore sample the count at chosen instants, or tie both clocks together and accept a one-count lag.

A carry output rises while the counter sits at its all-ones value with counting enabled. A longer counter is built by feeding that carry into the count-enable of the next stage. All stages in the chain share the count clock and the clear. Two such stages form a 16-bit address counter.

The output enable is modelled as a data gate plus a drive flag, not as a real high-impedance driver. While the enable is low, the data outputs read zero and the flag is low.

Top module: `cascade_count_reg`

## Requirements
- R1: While rst_ni is low, the counter and the holding register are zero, so q_o reads 8'h00 and rco_o is low.
- R2: On each rising count-clock edge with clr_ni high, the counter advances by one when cnt_en_i is high and keeps its value when cnt_en_i is low.
- R3: With clr_ni low at a rising count-clock edge, the counter becomes zero whatever cnt_en_i is; the clear is synchronous, active low, and overrides counting.
- R4: The holding register takes the counter's present value on each rising register-clock edge and keeps it between those edges, even while the counter moves.
- R5: With the count clock and register clock tied together, q_o always shows the value one count behind the counter.
- R6: rco_o is high exactly while the counter holds all ones and cnt_en_i is high; it is low at any other count or with counting disabled.
- R7: With oe_i high, q_o equals the holding register and q_drv_o is high. With oe_i low, q_o is 8'h00 and q_drv_o is low. oe_i has no effect on the holding register's contents.
- R8: In a two-stage chain (stage one's rco_o to stage two's cnt_en_i, shared clocks and clear), the upper stage advances only when the lower stage wraps. The 16-bit value goes from 16'hFFFF to 16'h0000 in one count step.
- R9: A single stage wraps from 8'hFF to 8'h00 on the next enabled count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cnt_i | input | 1 | Count clock, rising edge |
| clk_reg_i | input | 1 | Holding register clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable, high to advance |
| clr_ni | input | 1 | Synchronous counter clear, active low |
| oe_i | input | 1 | Output enable, high to present the register |
| q_o | output | WIDTH | Holding register value, zero when disabled |
| q_drv_o | output | 1 | High when q_o is valid and would be driven |
| rco_o | output | 1 | Carry out for chaining further stages |

## Verification
The hardest state to reach from the ports is the top of the 16-bit chain. There both carries are high together, and the next edge has to clear both bytes at once. Reaching it means holding count-enable high through 65,535 consecutive count edges from a cleared start. Until then the register clock is kept apart from the count clock, and the value is read with a single isolated register pulse. That lets the bench see FFFF before the wrap and 0000 after it, with no lag term to account for.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
package ccr_pkg;
  parameter int unsigned CCR_WIDTH = 8;
  typedef enum logic {OUT_OFF = 1'b0, OUT_ON = 1'b1} out_mode_e;
endpackage

// File: rtl/ccr_counter.sv
`timescale 1ns/1ps
module ccr_counter #(
  parameter int unsigned WIDTH = ccr_pkg::CCR_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_ni,
  output logic [WIDTH-1:0] cnt_o,
  output logic             term_o
);
  logic [WIDTH-1:0] cnt_q;

  // clear outranks enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!clr_ni) cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign term_o = &cnt_q;
endmodule

// File: rtl/ccr_hold_reg.sv
`timescale 1ns/1ps
module ccr_hold_reg #(
  parameter int unsigned WIDTH = ccr_pkg::CCR_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/ccr_out_stage.sv
`timescale 1ns/1ps
module ccr_out_stage #(
  parameter int unsigned WIDTH = ccr_pkg::CCR_WIDTH
) (
  input  logic             oe_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             drv_o
);
  ccr_pkg::out_mode_e mode;

  always_comb begin
    mode  = oe_i ? ccr_pkg::OUT_ON : ccr_pkg::OUT_OFF;
    q_o   = (mode == ccr_pkg::OUT_ON) ? d_i : '0;
    drv_o = (mode == ccr_pkg::OUT_ON);
  end
endmodule

// File: rtl/cascade_count_reg.sv
`timescale 1ns/1ps
module cascade_count_reg #(
  parameter int unsigned WIDTH = ccr_pkg::CCR_WIDTH
) (
  input  logic             clk_cnt_i,
  input  logic             clk_reg_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             clr_ni,
  input  logic             oe_i,
  output logic [WIDTH-1:0] q_o,
  output logic             q_drv_o,
  output logic             rco_o
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] reg_q;
  logic             term;

  ccr_counter #(.WIDTH(WIDTH)) i_counter (
    .clk_i  (clk_cnt_i),
    .rst_ni (rst_ni),
    .en_i   (cnt_en_i),
    .clr_ni (clr_ni),
    .cnt_o  (cnt_q),
    .term_o (term)
  );

  ccr_hold_reg #(.WIDTH(WIDTH)) i_hold_reg (
    .clk_i  (clk_reg_i),
    .rst_ni (rst_ni),
    .d_i    (cnt_q),
    .q_o    (reg_q)
  );

  ccr_out_stage #(.WIDTH(WIDTH)) i_out_stage (
    .oe_i  (oe_i),
    .d_i   (reg_q),
    .q_o   (q_o),
    .drv_o (q_drv_o)
  );

  // carry only while enabled, so the next stage steps with the wrap
  assign rco_o = term & cnt_en_i;
endmodule

// File: rtl/cascade_count_reg_chk.sv
`timescale 1ns/1ps
module cascade_count_reg_chk #(
  parameter int unsigned WIDTH = ccr_pkg::CCR_WIDTH
) (
  input logic             clk_cnt_i,
  input logic             clk_reg_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             clr_ni,
  input logic             oe_i,
  input logic [WIDTH-1:0] q_o,
  input logic             q_drv_o,
  input logic             rco_o,
  input logic [WIDTH-1:0] cnt_q_i,
  input logic [WIDTH-1:0] reg_q_i
);
  AST_CLEAR_ZERO: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
    !clr_ni |=> cnt_q_i == '0); // R3

  AST_COUNT_STEP: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
    (clr_ni && cnt_en_i) |=> cnt_q_i == WIDTH'($past(cnt_q_i) + 1'b1)); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
    (clr_ni && !cnt_en_i) |=> $stable(cnt_q_i)); // R2

  AST_CARRY_WRAP: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
    rco_o |=> cnt_q_i == '0); // R9

  AST_CARRY_GATED: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
    !cnt_en_i |-> !rco_o); // R6

  AST_REG_LOAD: assert property (@(posedge clk_reg_i) disable iff (!rst_ni)
    1'b1 |=> reg_q_i == $past(cnt_q_i)); // R4

  AST_OUT_OFF: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
    !oe_i |-> (q_o == '0 && !q_drv_o)); // R7

  AST_OUT_ON: assert property (@(posedge clk_cnt_i) disable iff (!rst_ni)
    oe_i |-> (q_o == reg_q_i && q_drv_o)); // R7
endmodule

bind cascade_count_reg cascade_count_reg_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_cnt_i (clk_cnt_i),
  .clk_reg_i (clk_reg_i),
  .rst_ni    (rst_ni),
  .cnt_en_i  (cnt_en_i),
  .clr_ni    (clr_ni),
  .oe_i      (oe_i),
  .q_o       (q_o),
  .q_drv_o   (q_drv_o),
  .rco_o     (rco_o),
  .cnt_q_i   (cnt_q),
  .reg_q_i   (reg_q)
);

// File: tb/test_cascade_count_reg.sv
`timescale 1ns/1ps
module test_cascade_count_reg;
  logic       clk = 1'b0;
  logic       man_clk = 1'b0;
  logic       tie = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       clr_n = 1'b1;
  logic       oe = 1'b1;
  logic [7:0] q_lo, q_hi;
  logic       drv_lo, drv_hi, rco_lo, rco_hi;
  logic       reg_clk;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;
  assign reg_clk = tie ? clk : man_clk;

  cascade_count_reg i_cascade_count_reg (
    .clk_cnt_i (clk), .clk_reg_i (reg_clk), .rst_ni (rst_n),
    .cnt_en_i (en), .clr_ni (clr_n), .oe_i (oe),
    .q_o (q_lo), .q_drv_o (drv_lo), .rco_o (rco_lo));

  cascade_count_reg i_cascade_count_reg_hi (
    .clk_cnt_i (clk), .clk_reg_i (reg_clk), .rst_ni (rst_n),
    .cnt_en_i (rco_lo), .clr_ni (clr_n), .oe_i (oe),
    .q_o (q_hi), .q_drv_o (drv_hi), .rco_o (rco_hi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one register pulse well away from the count edge
  task automatic snap();
    @(negedge clk);
    #0.5 man_clk = 1'b1;
    #0.5 man_clk = 1'b0;
    #0.2;
  endtask

  task automatic clear_both();
    @(negedge clk);
    clr_n = 1'b0; en = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 q_o", {24'h0, q_lo}, 32'h0);
    chk("R1 rco_o", {31'h0, rco_lo}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    snap();
    chk("R1 after release", {16'h0, q_hi, q_lo}, 32'h0);
  endtask

  task automatic t_enable();
    clear_both();
    en = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0;
    snap();
    chk("R2 count 5", {24'h0, q_lo}, 32'h5);
    repeat (3) @(negedge clk);
    snap();
    chk("R2 hold", {24'h0, q_lo}, 32'h5);
    en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    chk("R4 no reg edge", {24'h0, q_lo}, 32'h5);
    snap();
    chk("R4 reg loads", {24'h0, q_lo}, 32'h8);
  endtask

  task automatic t_clear();
    @(negedge clk);
    en = 1'b1; clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1; en = 1'b0;
    snap();
    chk("R3 clear over enable", {24'h0, q_lo}, 32'h0);
  endtask

  task automatic t_tied();
    clear_both();
    tie = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk("R5 lag first", {24'h0, q_lo}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R5 lag 4", {24'h0, q_lo}, 32'h3);
    en = 1'b0;
    @(negedge clk);
    chk("R5 settled", {24'h0, q_lo}, 32'h4);
    tie = 1'b0;
  endtask

  task automatic t_carry();
    clear_both();
    en = 1'b1;
    repeat (254) @(negedge clk);
    chk("R6 low at FE", {31'h0, rco_lo}, 32'h0);
    @(negedge clk);
    chk("R6 high at FF", {31'h0, rco_lo}, 32'h1);
    en = 1'b0;
    #0.1;
    chk("R6 gated by enable", {31'h0, rco_lo}, 32'h0);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    snap();
    chk("R9 low wraps", {24'h0, q_lo}, 32'h0);
    chk("R8 hi steps", {24'h0, q_hi}, 32'h1);
  endtask

  task automatic t_wrap16();
    clear_both();
    en = 1'b1;
    repeat (65535) @(negedge clk);
    chk("R8 chain carry", {31'h0, rco_hi}, 32'h1);
    en = 1'b0;
    snap();
    chk("R8 16-bit top", {16'h0, q_hi, q_lo}, 32'hFFFF);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    snap();
    chk("R8 16-bit wrap", {16'h0, q_hi, q_lo}, 32'h0);
  endtask

  task automatic t_oe();
    clear_both();
    en = 1'b1;
    repeat (7) @(negedge clk);
    en = 1'b0;
    oe = 1'b0;
    snap();
    chk("R7 q zero when off", {24'h0, q_lo}, 32'h0);
    chk("R7 drive low", {31'h0, drv_lo}, 32'h0);
    oe = 1'b1;
    #0.1;
    chk("R7 register kept", {24'h0, q_lo}, 32'h7);
    chk("R7 drive high", {31'h0, drv_lo}, 32'h1);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_clear();
    t_tied();
    t_carry();
    t_wrap16();
    t_oe();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule